// File: doc/BRIEF.md
# Privilege-Gated Event Counter Bank

This block holds a small set of event counters. Each counter has a setup register and a count register. On each clock a counter adds one when its chosen bit of the event vector is high and a gate is open. Three things form the gate: a global freeze input must be low, the counter's own privilege mask must allow the current privilege level, and a global start flag must be set. The counter's mode bit picks which start flag applies. A user-mode counter follows the user start flag and a privileged-mode counter follows the privileged start flag.

Software reaches the registers through one address port with a type select, an index, a write strobe and write data. Read data is combinational and always shows the addressed register. A count read may be forced to zero, depending on the privilege level, the counter's mode and a global secure flag. Counting goes on while reads are masked. A count register is 64 bits wide and wraps to zero.

Top module: `evtCounterBank`

## Requirements
- R1: After reset every count register and every setup register reads as zero, so no counter counts.
- R2: While `freeze` is 1, no count register changes unless it is written.
- R3: A counter counts only if bit `curPl` of its privilege mask (setup bits 3:0, bit n for level n) is 1.
- R4: Setup bit 6 is the mode. When it is 0 the counter counts only while `userEn` is 1. When it is 1 the counter counts only while `privEn` is 1.
- R5: When the gate is open and event bit `sel` is high, the counter adds exactly one in that cycle. Otherwise it holds its value. From all-ones it wraps to zero.
- R6: A count-register write (`regIsData`=1) loads the written value on the next edge. It overrides an increment in the same cycle.
- R7: The event select sits in setup bits 8 and up. Only its low `SEL_W` bits are stored. Setup bits 5:4, bit 7, the higher select bits and bits 63:16 ignore writes and read back as zero.
- R8: A privileged-mode counter's count reads as its value at level 0 and as zero at levels 1 to 3.
- R9: A user-mode counter with `secure` set reads as zero at levels 1 to 3 and as its value at level 0. It keeps counting while it reads as zero.
- R10: A user-mode counter with `secure` clear reads as its value at every level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Write strobe for the addressed register |
| regIsData | input | 1 | 1 addresses a count register, 0 a setup register |
| regIdx | input | IDX_W | Counter index |
| regWrData | input | 64 | Write data |
| regRdData | output | 64 | Read data of the addressed register, masked as per R8 to R10 |
| freeze | input | 1 | Global freeze |
| userEn | input | 1 | Start flag for user-mode counters |
| privEn | input | 1 | Start flag for privileged-mode counters |
| secure | input | 1 | Secures user-mode counters against non-zero levels |
| curPl | input | 2 | Current privilege level, 0 to 3 |
| events | input | EVT_W | Event vector, one bit per selectable event |

## Verification
A wrong gate decision shows at the ports one cycle later, as a count that has moved or held against expectation. A drift in one counter's value therefore appears the first time that counter is read. A wrong setup bit shows at once on a setup read-back and in the gating of later cycles. A masking fault shows combinationally in the same cycle as the read. So the reference model compares the read data on every clock, while privilege level, mode, secure flag and address are swept.

// File: rtl/evtCtrPkg.sv
package evtCtrPkg;
  typedef struct packed {
    logic load;
    logic inc;
  } ctrStrobe_t;

  localparam int NUM_PL   = 4;
  localparam int PLM_LSB  = 0;
  localparam int MODE_BIT = 6;
  localparam int SEL_LSB  = 8;
  localparam int SEL_MAX  = 8;
endpackage

// File: rtl/evtCtrCtrl.sv
module evtCtrCtrl
  import evtCtrPkg::*;
#(
  parameter int NUM_CTRS = 4,
  parameter int SEL_W    = 3,
  parameter int IDX_W    = 2,
  parameter int EVT_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWr,
  input  logic                 regIsData,
  input  logic [IDX_W-1:0]     regIdx,
  input  logic [63:0]          regWrData,
  input  logic                 freeze,
  input  logic                 userEn,
  input  logic                 privEn,
  input  logic                 secure,
  input  logic [1:0]           curPl,
  input  logic [EVT_W-1:0]     events,
  output ctrStrobe_t           strobes [NUM_CTRS],
  output logic                 rdZero,
  output logic [63:0]          cfgRdData
);
  logic [NUM_PL-1:0] plm  [NUM_CTRS];
  logic              mode [NUM_CTRS];
  logic [SEL_W-1:0]  sel  [NUM_CTRS];

  for (genvar i = 0; i < NUM_CTRS; i++) begin : g_cfg
    logic hitCfg, hitData, levelOk, startOk, evtHit;

    assign hitCfg  = regWr && !regIsData && (regIdx == IDX_W'(i));
    assign hitData = regWr &&  regIsData && (regIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        plm[i]  <= '0;
        mode[i] <= 1'b0;
        sel[i]  <= '0;
      end else if (hitCfg) begin
        plm[i]  <= regWrData[PLM_LSB +: NUM_PL];
        mode[i] <= regWrData[MODE_BIT];
        sel[i]  <= regWrData[SEL_LSB +: SEL_W];
      end
    end

    assign levelOk = plm[i][curPl];
    assign startOk = mode[i] ? privEn : userEn;
    assign evtHit  = (int'(sel[i]) < EVT_W) ? events[sel[i]] : 1'b0;

    assign strobes[i].load = hitData;
    assign strobes[i].inc  = !freeze && levelOk && startOk && evtHit;

    // R2
    freeze_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
      freeze |-> !strobes[i].inc);
    // R3
    level_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
      (curPl == 2'd0 && $past(hitCfg) && !$past(regWrData[PLM_LSB]))
      |-> !strobes[i].inc);
  end

  always_comb begin
    rdZero = 1'b0;
    if (curPl != 2'd0)
      rdZero = mode[regIdx] || secure;
  end

  always_comb begin
    cfgRdData = '0;
    cfgRdData[PLM_LSB +: NUM_PL] = plm[regIdx];
    cfgRdData[MODE_BIT]          = mode[regIdx];
    cfgRdData[SEL_LSB +: SEL_W]  = sel[regIdx];
  end
endmodule

// File: rtl/evtCtrData.sv
module evtCtrData
  import evtCtrPkg::*;
#(
  parameter int NUM_CTRS = 4,
  parameter int CTR_W    = 64,
  parameter int IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrStrobe_t       strobes [NUM_CTRS],
  input  logic [63:0]      wrData,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic             rdZero,
  output logic [63:0]      dataRdData
);
  logic [CTR_W-1:0] cnt [NUM_CTRS];

  for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (!rstN)                 cnt[i] <= '0;
      else if (strobes[i].load)  cnt[i] <= wrData[CTR_W-1:0];
      else if (strobes[i].inc)   cnt[i] <= cnt[i] + 1'b1;
    end

    // R5
    inc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[i].inc && !strobes[i].load) |=> cnt[i] == $past(cnt[i]) + 1'b1);
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes[i].inc && !strobes[i].load) |=> $stable(cnt[i]));
    // R6
    load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobes[i].load |=> cnt[i] == $past(wrData[CTR_W-1:0]));
  end

  assign dataRdData = rdZero ? 64'd0 : 64'(cnt[rdIdx]);
endmodule

// File: rtl/evtCounterBank.sv
module evtCounterBank
  import evtCtrPkg::*;
#(
  parameter int NUM_CTRS = 4,
  parameter int CTR_W    = 64,
  parameter int SEL_W    = 3,
  localparam int IDX_W   = (NUM_CTRS > 1) ? $clog2(NUM_CTRS) : 1,
  localparam int EVT_W   = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regIsData,
  input  logic [IDX_W-1:0] regIdx,
  input  logic [63:0]      regWrData,
  output logic [63:0]      regRdData,
  input  logic             freeze,
  input  logic             userEn,
  input  logic             privEn,
  input  logic             secure,
  input  logic [1:0]       curPl,
  input  logic [EVT_W-1:0] events
);
  ctrStrobe_t  strobes [NUM_CTRS];
  logic        rdZero;
  logic [63:0] cfgRdData, dataRdData;

  evtCtrCtrl #(.NUM_CTRS(NUM_CTRS), .SEL_W(SEL_W), .IDX_W(IDX_W), .EVT_W(EVT_W))
  i_ctrl (
    .clk, .rstN, .regWr, .regIsData, .regIdx, .regWrData,
    .freeze, .userEn, .privEn, .secure, .curPl, .events,
    .strobes, .rdZero, .cfgRdData
  );

  evtCtrData #(.NUM_CTRS(NUM_CTRS), .CTR_W(CTR_W), .IDX_W(IDX_W))
  i_data (
    .clk, .rstN, .strobes, .wrData(regWrData), .rdIdx(regIdx),
    .rdZero, .dataRdData
  );

  assign regRdData = regIsData ? dataRdData : cfgRdData;

  // R8
  priv_level_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regIsData && curPl != 2'd0 && cfgRdData[MODE_BIT]) |-> regRdData == 64'd0);
  // R10
  user_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regIsData && !secure && !cfgRdData[MODE_BIT]) |-> !rdZero);
  // R7
  initial begin
    sel_width_chk: assert (SEL_W >= 1 && SEL_W <= SEL_MAX && CTR_W <= 64);
  end
endmodule

// File: tb/test_evtCounterBank.sv
`timescale 1ns/1ps
module test_evtCounterBank;
  localparam int N = 4;
  localparam int SEL_W = 3;
  localparam int EVT_W = 1 << SEL_W;
  localparam longint unsigned CFG_MASK =
    64'hF | (64'h1 << 6) | (64'((1 << SEL_W) - 1) << 8);

  logic clk = 0, rstN = 0;
  logic regWr = 0, regIsData = 0;
  logic [1:0] regIdx = 0;
  logic [63:0] regWrData = 0, regRdData;
  logic freeze = 0, userEn = 0, privEn = 0, secure = 0;
  logic [1:0] curPl = 0;
  logic [EVT_W-1:0] events = 0;

  int checks = 0, errors = 0;
  longint unsigned mCnt [N];
  longint unsigned mCfg [N];

  always #10 clk = ~clk;

  evtCounterBank i_evtCounterBank (.*);

  function automatic longint unsigned modelRead();
    longint unsigned c;
    bit pm;
    if (!regIsData) return mCfg[regIdx];
    c  = mCnt[regIdx];
    pm = mCfg[regIdx][6];
    if (pm) return (curPl == 0) ? c : 0;
    if (secure && curPl != 0) return 0;
    return c;
  endfunction

  function automatic bit modelEn(int i);
    bit lvl, st;
    int s;
    lvl = mCfg[i][curPl];
    st  = mCfg[i][6] ? privEn : userEn;
    s   = int'((mCfg[i] >> 8) & 64'((1 << SEL_W) - 1));
    return !freeze && lvl && st && events[s];
  endfunction

  task automatic tick(string tag);
    longint unsigned exp, nCnt [N], nCfg [N];
    #1;
    exp = modelRead();
    checks++;
    if (regRdData !== exp) begin
      errors++;
      $display("FAIL %s: idx=%0d data=%0b pl=%0d actual=%h expected=%h",
               tag, regIdx, regIsData, curPl, regRdData, exp);
    end
    for (int i = 0; i < N; i++) begin
      nCnt[i] = mCnt[i];
      nCfg[i] = mCfg[i];
      if (regWr && regIsData && regIdx == 2'(i)) nCnt[i] = regWrData;
      else if (modelEn(i)) nCnt[i] = mCnt[i] + 1;
      if (regWr && !regIsData && regIdx == 2'(i)) nCfg[i] = regWrData & CFG_MASK;
    end
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      mCnt[i] = nCnt[i];
      mCfg[i] = nCfg[i];
    end
    @(negedge clk);
  endtask

  task automatic wrReg(bit isData, int idx, longint unsigned v, string tag);
    regWr = 1; regIsData = isData; regIdx = 2'(idx); regWrData = v;
    tick(tag);
    regWr = 0;
  endtask

  task automatic rdReg(bit isData, int idx, int n, string tag);
    regIsData = isData; regIdx = 2'(idx);
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mCnt[i] = 0; mCfg[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state of all registers
    for (int i = 0; i < N; i++) begin
      rdReg(0, i, 1, "R1");
      rdReg(1, i, 1, "R1");
    end
    // R7: junk in ignored bits; stored select = 0xFA & 7 = 2
    wrReg(0, 0, 64'hABCD_0000_0000_FAB0 | 64'hF, "R7");
    rdReg(0, 0, 1, "R7");
    wrReg(0, 1, 64'h541, "R7");
    wrReg(0, 2, 64'h002, "R7");
    wrReg(0, 3, 64'h74F, "R7");
    rdReg(0, 3, 1, "R7");
    // R5: user counter counting on hot events
    userEn = 1; events = 8'hFF;
    rdReg(1, 0, 4, "R5");
    events = 8'h04;
    rdReg(1, 0, 2, "R5");
    events = 8'h03;
    rdReg(1, 0, 2, "R5");
    // R4: privileged counters idle while privEn is low
    events = 8'hFF;
    rdReg(1, 1, 2, "R4");
    userEn = 0; privEn = 1;
    rdReg(1, 0, 3, "R4");
    rdReg(1, 1, 3, "R4");
    // R3: level 1 stops ctr1 (mask 0001), ctr3 (mask 1111) continues
    curPl = 1;
    rdReg(1, 3, 3, "R8");
    rdReg(1, 1, 3, "R8");
    curPl = 0;
    rdReg(1, 1, 1, "R3");
    rdReg(1, 3, 1, "R3");
    // R2: freeze
    userEn = 1; freeze = 1;
    rdReg(1, 0, 3, "R2");
    rdReg(1, 3, 2, "R2");
    freeze = 0;
    // R6: write wins over event
    wrReg(1, 0, 64'd5, "R6");
    rdReg(1, 0, 2, "R6");
    // R5: wrap to zero
    wrReg(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
    rdReg(1, 0, 2, "R5");
    // R9: secured user counter counts at level 1 but reads zero
    events = 8'h01; secure = 1; curPl = 1;
    rdReg(1, 2, 4, "R9");
    curPl = 0;
    rdReg(1, 2, 1, "R9");
    // R10: unsecured reads at every level
    secure = 0;
    for (int p = 0; p < 4; p++) begin
      curPl = 2'(p);
      rdReg(1, 2, 1, "R10");
      rdReg(1, 0, 1, "R10");
    end
    // R5: mixed stimulus
    for (int k = 0; k < 3000; k++) begin
      events    = EVT_W'($urandom);
      freeze    = ($urandom % 8) == 0;
      userEn    = $urandom;
      privEn    = $urandom;
      secure    = $urandom;
      curPl     = 2'($urandom);
      regIsData = $urandom;
      regIdx    = 2'($urandom);
      regWr     = ($urandom % 16) == 0;
      regWrData = {$urandom, $urandom};
      tick("R5");
    end
    regWr = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule